// File: doc/BRIEF.md
# Character Generator Extension Controller

This block sits on a CPU peripheral bus next to a text-mode video generator and adds a software-programmable character RAM to it. A 32-byte peripheral window is cut into eight 4-byte blocks: block 0 is handed to the original peripheral through a select output, block 1 holds this controller's two registers, and blocks 2 to 7 decode to nothing.

The control register chooses whether glyphs come from the generator's built-in font or from the external RAM, and derives the invert and semigraphics attributes either from bits 6 and 7 of the display byte or from manual levels. Software loads the external RAM one byte at a time: it steps an 11-bit address counter by toggling a clock bit in the control register, and writes the byte through the data register, which raises a one-cycle write strobe. The strobe is only released while writing is enabled and the built-in font is on screen.

Top module: `chargen_ext_ctrl`

## Requirements
- R1: With cs_i high, addr_i[4:2] picks a block: 0 raises orig_sel_o, 1 raises sel_o, 2 to 7 raise neither; with cs_i low both are low. Writes outside block 1 change no register.
- R2: In block 1, addr_i[0]=0 reaches the control register and addr_i[0]=1 the data register, so offsets 4/6 alias to control and 5/7 to data; a read (we_i low) returns the last value written, and rdata_o is 0 when block 1 is not being read.
- R3: ext_src_o equals control bit 0 (1 = external character RAM).
- R4: With control bit 1 set, invert_o follows disp_data_i[6]; with it clear, invert_o equals control bit 2.
- R5: With control bit 3 set, semig_o follows disp_data_i[7]; with it clear, semig_o equals control bit 4.
- R6: cram_we_o stays low for a data-register write made while control bit 5 is 0.
- R7: cram_we_o stays low for a data-register write made while control bit 0 is 1, even with bit 5 set.
- R8: A data-register write made with bit 5 set and bit 0 clear drives cram_we_o high for exactly the cycle after the write edge, with cram_wdata_o equal to the written byte and cram_addr_o unchanged by that write.
- R9: cram_addr_o increments by one in the cycle after a control write that takes bit 6 from 0 to 1; rewriting bit 6 as 1, or clearing it, leaves the counter unchanged.
- R10: cram_addr_o is 11 bits and wraps from 2047 to 0.
- R11: rst_ni low clears both registers and the address counter, so all video and RAM outputs read 0.
- R12: Control bit 7 stores and reads back but changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Peripheral window select |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Offset inside the 32-byte window |
| wdata_i | input | 8 | CPU write data |
| rdata_o | output | 8 | CPU read data |
| orig_sel_o | output | 1 | Select for the original peripheral (block 0) |
| sel_o | output | 1 | This controller addressed (block 1) |
| disp_data_i | input | 8 | Display data byte from video memory |
| ext_src_o | output | 1 | Glyph source: 0 built-in, 1 external RAM |
| invert_o | output | 1 | Invert attribute to the pixel generator |
| semig_o | output | 1 | Semigraphics attribute to the pixel generator |
| cram_addr_o | output | 11 | Character RAM address counter |
| cram_wdata_o | output | 8 | Character RAM write data |
| cram_we_o | output | 1 | Character RAM write strobe |

## Verification
On every cycle the assertions hold the attribute muxes to their selected sources, keep the two block selects exclusive, allow a write strobe only one cycle after a data write made with writing open and the built-in font selected, and allow the address counter to move only by one, only after the clock bit was high. Only the bench scenarios show register aliasing and read-back, that a held or falling clock bit does not step the counter, the 2047-to-0 wrap, the written byte arriving with the strobe, and that bit 7 has no effect.

// File: rtl/chargen_ext_pkg.sv
package chargen_ext_pkg;
  localparam int unsigned REG_W = 8;

  // bit order is software-visible
  typedef struct packed {
    logic spare;      // 7
    logic clk_tog;    // 6
    logic wr_open;    // 5
    logic semi_man;   // 4
    logic semi_auto;  // 3
    logic inv_man;    // 2
    logic inv_auto;   // 1
    logic src_ext;    // 0
  } ctrl_t;

  localparam int unsigned INV_DISP_BIT  = 6;
  localparam int unsigned SEMI_DISP_BIT = 7;
endpackage

// File: rtl/cx_addr_dec.sv
module cx_addr_dec #(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned BLK_W   = 3,
  parameter int unsigned OWN_BLK = 1
) (
  input  logic              cs_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              orig_sel_o,
  output logic              own_sel_o,
  output logic              is_data_o
);
  localparam int unsigned NBLK  = 1 << BLK_W;
  localparam int unsigned OFS_W = ADDR_W - BLK_W;

  logic [NBLK-1:0] blk_hit;

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    assign blk_hit[b] = cs_i && (addr_i[ADDR_W-1:OFS_W] == BLK_W'(b));
  end

  assign orig_sel_o = blk_hit[0];
  assign own_sel_o  = blk_hit[OWN_BLK];
  assign is_data_o  = addr_i[0];
endmodule

// File: rtl/cx_regs.sv
module cx_regs
  import chargen_ext_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic             is_data_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output ctrl_t            ctrl_o,
  output logic [REG_W-1:0] data_o,
  output logic             data_wr_o
);
  logic ctrl_wr;

  assign ctrl_wr   = sel_i && we_i && !is_data_i;
  assign data_wr_o = sel_i && we_i && is_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      data_o <= '0;
    end else begin
      if (ctrl_wr)   ctrl_o <= ctrl_t'(wdata_i);
      if (data_wr_o) data_o <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i && !we_i) rdata_o = is_data_i ? data_o : REG_W'(ctrl_o);
  end
endmodule

// File: rtl/cx_attr_sel.sv
module cx_attr_sel (
  input  logic auto_i,
  input  logic man_i,
  input  logic disp_bit_i,
  output logic attr_o
);
  assign attr_o = auto_i ? disp_bit_i : man_i;
endmodule

// File: rtl/cx_cram_port.sv
module cx_cram_port #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tog_i,
  input  logic             data_wr_i,
  input  logic             wr_open_i,
  input  logic             src_ext_i,
  output logic [CNT_W-1:0] addr_o,
  output logic             we_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q  <= 1'b0;
      addr_o <= '0;
      we_o   <= 1'b0;
    end else begin
      tog_q <= tog_i;
      if (tog_i && !tog_q) addr_o <= addr_o + 1'b1;  // wraps naturally
      // gate evaluated against control state at the write edge
      we_o <= data_wr_i && wr_open_i && !src_ext_i;
    end
  end
endmodule

// File: rtl/chargen_ext_ctrl.sv
module chargen_ext_ctrl
  import chargen_ext_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned BLK_W   = 3,
  parameter int unsigned OWN_BLK = 1,
  parameter int unsigned CNT_W   = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              orig_sel_o,
  output logic              sel_o,
  input  logic [REG_W-1:0]  disp_data_i,
  output logic              ext_src_o,
  output logic              invert_o,
  output logic              semig_o,
  output logic [CNT_W-1:0]  cram_addr_o,
  output logic [REG_W-1:0]  cram_wdata_o,
  output logic              cram_we_o
);
  localparam int unsigned NATTR = 2;

  logic             is_data;
  logic             data_wr;
  ctrl_t            ctrl_q;
  logic [REG_W-1:0] data_q;

  cx_addr_dec #(
    .ADDR_W (ADDR_W),
    .BLK_W  (BLK_W),
    .OWN_BLK(OWN_BLK)
  ) u_dec (
    .cs_i      (cs_i),
    .addr_i    (addr_i),
    .orig_sel_o(orig_sel_o),
    .own_sel_o (sel_o),
    .is_data_o (is_data)
  );

  cx_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_o),
    .we_i     (we_i),
    .is_data_i(is_data),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .ctrl_o   (ctrl_q),
    .data_o   (data_q),
    .data_wr_o(data_wr)
  );

  logic [NATTR-1:0] attr_auto, attr_man, attr_disp, attr_out;

  assign attr_auto = {ctrl_q.semi_auto, ctrl_q.inv_auto};
  assign attr_man  = {ctrl_q.semi_man, ctrl_q.inv_man};
  assign attr_disp = {disp_data_i[SEMI_DISP_BIT], disp_data_i[INV_DISP_BIT]};

  for (genvar a = 0; a < NATTR; a++) begin : g_attr
    cx_attr_sel u_sel (
      .auto_i    (attr_auto[a]),
      .man_i     (attr_man[a]),
      .disp_bit_i(attr_disp[a]),
      .attr_o    (attr_out[a])
    );
  end

  assign invert_o  = attr_out[0];
  assign semig_o   = attr_out[1];
  assign ext_src_o = ctrl_q.src_ext;

  cx_cram_port #(.CNT_W(CNT_W)) u_cram (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tog_i    (ctrl_q.clk_tog),
    .data_wr_i(data_wr),
    .wr_open_i(ctrl_q.wr_open),
    .src_ext_i(ctrl_q.src_ext),
    .addr_o   (cram_addr_o),
    .we_o     (cram_we_o)
  );

  assign cram_wdata_o = data_q;
endmodule

// File: rtl/chargen_ext_chk.sv
module chargen_ext_chk #(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned BLK_W   = 3,
  parameter int unsigned OWN_BLK = 1,
  parameter int unsigned CNT_W   = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        disp_data_i,
  input logic [7:0]        ctrl_i,
  input logic              orig_sel_o,
  input logic              sel_o,
  input logic              ext_src_o,
  input logic              invert_o,
  input logic              semig_o,
  input logic [CNT_W-1:0]  cram_addr_o,
  input logic              cram_we_o
);
  localparam int unsigned OFS_W = ADDR_W - BLK_W;

  logic data_wr_req;
  assign data_wr_req = cs_i && we_i && addr_i[0] &&
                       (addr_i[ADDR_W-1:OFS_W] == BLK_W'(OWN_BLK));

  assert_sel_excl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({orig_sel_o, sel_o}));

  assert_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_src_o == ctrl_i[0]);

  assert_inv_auto_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[1] |-> invert_o == disp_data_i[6]);

  assert_inv_man_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[1] |-> invert_o == ctrl_i[2]);

  assert_semi_auto_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[3] |-> semig_o == disp_data_i[7]);

  assert_semi_man_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[3] |-> semig_o == ctrl_i[4]);

  assert_we_open_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cram_we_o |-> $past(ctrl_i[5]));

  assert_we_lock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cram_we_o |-> !$past(ctrl_i[0]));

  assert_we_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cram_we_o |-> $past(data_wr_req));

  assert_step_clk_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cram_addr_o != $past(cram_addr_o)) |-> $past(ctrl_i[6]));

  assert_step_one_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cram_addr_o != $past(cram_addr_o)) |->
      cram_addr_o == CNT_W'($past(cram_addr_o) + 1'b1));
endmodule

bind chargen_ext_ctrl chargen_ext_chk #(
  .ADDR_W (ADDR_W),
  .BLK_W  (BLK_W),
  .OWN_BLK(OWN_BLK),
  .CNT_W  (CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_i       (cs_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .disp_data_i(disp_data_i),
  .ctrl_i     (ctrl_q),
  .orig_sel_o (orig_sel_o),
  .sel_o      (sel_o),
  .ext_src_o  (ext_src_o),
  .invert_o   (invert_o),
  .semig_o    (semig_o),
  .cram_addr_o(cram_addr_o),
  .cram_we_o  (cram_we_o)
);

// File: tb/tb_chargen_ext_ctrl.sv
module tb_chargen_ext_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_i = 1'b0, we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0, disp_data_i = '0;
  logic [7:0]  rdata_o, cram_wdata_o;
  logic        orig_sel_o, sel_o, ext_src_o, invert_o, semig_o, cram_we_o;
  logic [10:0] cram_addr_o;

  int total = 0, bad = 0, strobes = 0;
  bit done = 0;
  logic [18:0] exp_q[$];
  logic [7:0]  ctrl_m = '0;
  logic [10:0] cnt_m = '0;

  always #4 clk_i = ~clk_i;

  chargen_ext_ctrl dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // driver: one bus write, expectations pushed to scoreboard
  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk_i);
    cs_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    if (a[4:2] == 3'd1) begin
      if (!a[0]) ctrl_m = d;
      else if (ctrl_m[5] && !ctrl_m[0]) exp_q.push_back({cnt_m, d});
    end
    @(negedge clk_i);
    cs_i = 0; we_i = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    @(negedge clk_i);
    cs_i = 1; we_i = 0; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    cs_i = 0;
  endtask

  // toggle clock bit keeping other bits
  task automatic step();
    wr(5'h04, ctrl_m | 8'h40);
    cnt_m++;
    wr(5'h04, ctrl_m & 8'hBF);
  endtask

  // monitor: pop and compare each strobe
  always @(negedge clk_i) begin
    if (rst_ni && cram_we_o) begin
      strobes++;
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R6 R7 unexpected strobe act=1 exp=0");
      end else begin
        logic [18:0] e;
        e = exp_q.pop_front();
        if ({cram_addr_o, cram_wdata_o} !== e) begin
          bad++;
          $display("FAIL R8 act=%0h exp=%0h", {cram_addr_o, cram_wdata_o}, e);
        end
      end
    end
  end

  initial begin
    logic [7:0] r;
    int s0;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk("R11 addr", cram_addr_o, 0);
    chk("R11 attrs", {ext_src_o, invert_o, semig_o, cram_we_o}, 0);
    rst_ni = 1;

    // R1 decode
    for (int b = 0; b < 8; b++) begin
      @(negedge clk_i);
      cs_i = 1; addr_i = 5'(b << 2);
      #1 chk($sformatf("R1 blk%0d", b), {orig_sel_o, sel_o}, {b == 0, b == 1});
    end
    @(negedge clk_i); cs_i = 0; addr_i = 5'h04;
    #1 chk("R1 cs low", {orig_sel_o, sel_o}, 0);
    rd(5'h04, r); chk("R11 ctrl rd", r, 0);
    rd(5'h05, r); chk("R11 data rd", r, 0);

    // R2 aliasing, R12 spare bit
    wr(5'h04, 8'h80);
    rd(5'h06, r); chk("R2 ctrl alias", r, 8'h80);
    chk("R12 no effect", {ext_src_o, invert_o, semig_o}, 0);
    wr(5'h07, 8'h5A);
    rd(5'h05, r); chk("R2 data alias", r, 8'h5A);
    wr(5'h08, 8'hFF);                    // block 2: no effect
    wr(5'h00, 8'hFF);                    // block 0: no effect
    rd(5'h04, r); chk("R1 ctrl untouched", r, 8'h80);
    rd(5'h05, r); chk("R1 data untouched", r, 8'h5A);
    rd(5'h0C, r); chk("R2 rd outside", r, 0);

    // R3
    wr(5'h04, 8'h01); #1 chk("R3 ext", ext_src_o, 1);
    wr(5'h04, 8'h00); #1 chk("R3 int", ext_src_o, 0);

    // R4/R5 auto
    wr(5'h04, 8'h0A);
    disp_data_i = 8'h40; #1 chk("R4 R5 auto 40", {invert_o, semig_o}, 2'b10);
    disp_data_i = 8'h80; #1 chk("R4 R5 auto 80", {invert_o, semig_o}, 2'b01);
    disp_data_i = 8'hC0; #1 chk("R4 R5 auto C0", {invert_o, semig_o}, 2'b11);
    disp_data_i = 8'h3F; #1 chk("R4 R5 auto 3F", {invert_o, semig_o}, 2'b00);
    // manual
    wr(5'h04, 8'h14);
    disp_data_i = 8'h00; #1 chk("R4 R5 man hi", {invert_o, semig_o}, 2'b11);
    wr(5'h04, 8'h00);
    disp_data_i = 8'hC0; #1 chk("R4 R5 man lo", {invert_o, semig_o}, 2'b00);
    wr(5'h04, 8'h04);
    #1 chk("R4 man inv only", {invert_o, semig_o}, 2'b10);

    // R6: closed
    s0 = strobes;
    wr(5'h04, 8'h00); wr(5'h05, 8'h11);
    @(negedge clk_i); chk("R6 no strobe", strobes - s0, 0);

    // R8: strobe, counter held
    wr(5'h04, 8'h20); wr(5'h05, 8'hA5);
    @(negedge clk_i);
    chk("R8 one strobe", strobes - s0, 1);
    chk("R8 addr held", cram_addr_o, 0);

    // R9: rising edge steps counter
    step(); @(negedge clk_i);
    chk("R9 step", cram_addr_o, 1);
    wr(5'h04, 8'h60); cnt_m++; wr(5'h04, 8'h60); @(negedge clk_i);
    chk("R9 held high", cram_addr_o, 2);
    wr(5'h04, 8'h20); @(negedge clk_i);
    chk("R9 falling", cram_addr_o, 2);
    wr(5'h07, 8'h3C); @(negedge clk_i);
    chk("R8 second strobe", strobes - s0, 2);

    // R7: locked while external source
    wr(5'h04, 8'h21); wr(5'h05, 8'h77);
    @(negedge clk_i); chk("R7 locked", strobes - s0, 2);
    wr(5'h04, 8'h20);

    // R10 wrap
    while (cnt_m != 11'd2047) step();
    @(negedge clk_i); chk("R10 max", cram_addr_o, 11'd2047);
    step(); @(negedge clk_i); chk("R10 wrap", cram_addr_o, 0);
    wr(5'h05, 8'hE1); @(negedge clk_i);
    chk("R10 R8 strobe at 0", strobes - s0, 3);

    // R11 mid-run reset
    step(); wr(5'h04, 8'h1F);
    @(negedge clk_i); rst_ni = 0; #1;
    chk("R11 run addr", cram_addr_o, 0);
    chk("R11 run attrs", {ext_src_o, invert_o, semig_o, cram_we_o}, 0);
    @(negedge clk_i); rst_ni = 1;
    rd(5'h04, r); chk("R11 run ctrl", r, 0);
    chk("R8 queue drained", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule